// File: doc/BRIEF.md
# Byte-Logic Instruction Execute Unit

This block executes the bitwise byte instructions of a classic 8-bit accumulator microcontroller: OR, AND and XOR in every addressing form, plus complement of the accumulator. A pulse on `start` makes the unit pull the opcode and any operand bytes through a request/valid fetch port, one byte per accepted request. It reads operands from the accumulator, from the working registers, from internal RAM (direct or through R0/R1) or from an immediate byte. The result goes either to the accumulator or back to a direct address.

Timing is counted in machine cycles of `TICKS_PER_CYC` clocks. A fetch stall freezes the tick count, so stalls only stretch the instruction. On the last tick `done` pulses. At the same time `instr_len` gives the byte count and `instr_cyc` gives the machine-cycle count. Read-modify-write instructions with a direct destination raise `ram_rd_latch` during their read. A port register at that address then returns its output latch and not its pin level.

The accumulator and RAM are held outside the block. The surrounding core feeds the accumulator in on `acc_in` and applies the write strobes.

Top module: `bytelogic_exec`

## Requirements
- R1: Opcode bits 7:4 pick the operation (0x4 OR, 0x5 AND, 0x6 XOR). Bits 3:0 pick the form: 0x2 direct destination with accumulator source, 0x3 direct destination with immediate source, 0x4 accumulator with immediate, 0x5 accumulator with direct, 0x6/0x7 accumulator with indirect, 0x8-0xF accumulator with register.
- R2: Opcode 0xF4 writes the bitwise complement of the accumulator back to the accumulator. It is one byte and one machine cycle long.
- R3: In register forms, opcode bits 2:0 give the register index n. The register is read from the direct RAM address bank_sel*8+n.
- R4: In indirect forms, opcode bit 0 picks R0 or R1 of the current bank. That register's value addresses the indirect RAM space, with `ram_ind`=1 and `ram_re`=1.
- R5: Direct-destination forms read the old value with `ram_rd_latch`=1. The accumulator-destination direct form reads with `ram_rd_latch`=0, so it sees the pin value of a port.
- R6: Bytes are consumed in the order opcode, address, data. Forms x3 are 3 bytes long. Forms x2, x4 and x5 are 2 bytes. Register, indirect and 0xF4 forms are 1 byte. `instr_len` reports this length at `done`.
- R7: Forms x3 take 2 machine cycles and all others take 1. `done` is a one-clock pulse, TICKS_PER_CYC*cycles clocks after the start is accepted, when there is no stall. `instr_cyc` reports the count.
- R8: A legal instruction performs exactly one write. Accumulator-destination forms write only the accumulator. Direct-destination forms write only RAM, at the address byte.
- R9: Any other opcode (low nibble 0x0/0x1 of groups 4-6, and every other high nibble except 0xF4) raises `illegal` with `done`, makes no write, and reports length 1 and 1 cycle.
- R10: Each clock with `fetch_req`=1 and `fetch_valid`=0 holds the tick count, so it adds exactly one clock to the instruction.
- R11: After reset `fetch_req`, `done`, `acc_we`, `ram_we` and `illegal` are 0 until a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| bank_sel | input | BANK_W | Working register bank |
| fetch_req | output | 1 | Request next instruction byte |
| fetch_valid | input | 1 | Byte on fetch_byte is valid this clock |
| fetch_byte | input | DATA_W | Instruction byte |
| acc_in | input | DATA_W | Current accumulator value |
| acc_we | output | 1 | Accumulator write strobe |
| acc_wdata | output | DATA_W | Accumulator write data |
| ram_addr | output | ADDR_W | RAM read/write address |
| ram_ind | output | 1 | Access targets indirect address space |
| ram_re | output | 1 | RAM read strobe |
| ram_rd_latch | output | 1 | Read for modify: ports return their output latch |
| ram_rdata | input | DATA_W | RAM read data (same clock) |
| ram_we | output | 1 | RAM write strobe (direct space) |
| ram_wdata | output | DATA_W | RAM write data |
| done | output | 1 | Last tick of the instruction |
| instr_len | output | 2 | Instruction length in bytes |
| instr_cyc | output | 2 | Machine cycles taken |
| illegal | output | 1 | Opcode not handled, with done |

## Verification
Each operation runs with operand pairs whose OR, AND and XOR results all differ, so a wrong function select shows up at once. Register and indirect forms run in nonzero banks, with values stored so that a wrong bank, wrong index or wrong pointer returns a distinct byte. One port address holds a latch value that is the complement of its pin value. This separates read-modify-write from the pin read. Two-cycle forms, fetch stalls and undefined opcodes check the done timing, the length reporting and that nothing is written.

// File: rtl/bl_pkg.sv
package bl_pkg;

  typedef enum logic [1:0] {OP_OR, OP_AND, OP_XOR, OP_CPL} alu_op_e;

  typedef enum logic [2:0] {
    FM_DIR_ACC, FM_DIR_IMM, FM_ACC_IMM, FM_ACC_DIR,
    FM_ACC_IND, FM_ACC_REG, FM_ACC_CPL
  } form_e;

  typedef enum logic [2:0] {
    S_IDLE, S_OPC, S_ADR, S_IMM, S_PTR, S_OPR, S_EXE, S_HOLD
  } state_e;

  typedef struct packed {
    logic    legal;
    alu_op_e op;
    form_e   form;
    logic [1:0] len;
    logic [1:0] cyc;
  } dec_t;

  // Opcode split: high nibble = operation group, low nibble = form.
  function automatic dec_t decode_op(input logic [7:0] opc);
    dec_t d;
    d.legal = 1'b0;
    d.op    = OP_OR;
    d.form  = FM_ACC_CPL;
    d.len   = 2'd1;
    d.cyc   = 2'd1;
    if (opc == 8'hF4) begin
      d.legal = 1'b1;
      d.op    = OP_CPL;
    end else if (opc[7:4] >= 4'h4 && opc[7:4] <= 4'h6 && opc[3:0] >= 4'h2) begin
      d.legal = 1'b1;
      case (opc[7:4])
        4'h4:    d.op = OP_OR;
        4'h5:    d.op = OP_AND;
        default: d.op = OP_XOR;
      endcase
      if (opc[3])                     d.form = FM_ACC_REG;
      else if (opc[2:1] == 2'b11)     d.form = FM_ACC_IND;
      else begin
        case (opc[2:0])
          3'd2:    begin d.form = FM_DIR_ACC; d.len = 2'd2; end
          3'd3:    begin d.form = FM_DIR_IMM; d.len = 2'd3; d.cyc = 2'd2; end
          3'd4:    begin d.form = FM_ACC_IMM; d.len = 2'd2; end
          default: begin d.form = FM_ACC_DIR; d.len = 2'd2; end
        endcase
      end
    end
    return d;
  endfunction

  function automatic logic [7:0] logic_op(input alu_op_e op, input logic [7:0] a,
                                          input logic [7:0] b);
    case (op)
      OP_OR:   return a | b;
      OP_AND:  return a & b;
      OP_XOR:  return a ^ b;
      default: return ~a;
    endcase
  endfunction

endpackage

// File: rtl/bl_decode.sv
module bl_decode
  import bl_pkg::*;
(
  input  logic [7:0] opcode,
  output dec_t       dec,
  output logic       dest_mem,
  output logic       needs_addr,
  output logic       needs_imm
);
  always_comb begin
    dec        = decode_op(opcode);
    dest_mem   = dec.legal && (dec.form == FM_DIR_ACC || dec.form == FM_DIR_IMM);
    needs_addr = dec.legal && (dec.form == FM_DIR_ACC || dec.form == FM_DIR_IMM ||
                               dec.form == FM_ACC_DIR);
    needs_imm  = dec.legal && (dec.form == FM_DIR_IMM || dec.form == FM_ACC_IMM);
  end
endmodule

// File: rtl/bl_alu.sv
module bl_alu
  import bl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb y = logic_op(op, a, b);
endmodule

// File: rtl/bl_seq.sv
module bl_seq
  import bl_pkg::*;
#(
  parameter int TICKS_PER_CYC = 12,
  parameter int MAX_CYC       = 2,
  localparam int TICK_W       = $clog2(TICKS_PER_CYC * MAX_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fetch_valid,
  input  dec_t              dec,
  input  logic              needs_addr,
  input  logic              needs_imm,
  output state_e            state,
  output logic [TICK_W-1:0] tick,
  output logic              fetch_req,
  output logic              done
);
  state_e            nxt;
  logic              stall;
  logic [TICK_W-1:0] last_tick;

  assign fetch_req = (state == S_OPC) || (state == S_ADR) || (state == S_IMM);
  assign stall     = fetch_req && !fetch_valid;
  assign last_tick = TICK_W'(TICKS_PER_CYC * int'(dec.cyc) - 1);
  assign done      = (state == S_HOLD) && (tick == last_tick);

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE: if (start) nxt = S_OPC;
      S_OPC: if (fetch_valid) begin
        if (!dec.legal)                 nxt = S_HOLD;
        else if (needs_addr)            nxt = S_ADR;
        else if (needs_imm)             nxt = S_IMM;
        else if (dec.form == FM_ACC_IND) nxt = S_PTR;
        else if (dec.form == FM_ACC_REG) nxt = S_OPR;
        else                            nxt = S_EXE;
      end
      S_ADR: if (fetch_valid) nxt = needs_imm ? S_IMM : S_OPR;
      S_IMM: if (fetch_valid) nxt = (dec.form == FM_DIR_IMM) ? S_OPR : S_EXE;
      S_PTR:  nxt = S_OPR;
      S_OPR:  nxt = S_EXE;
      S_EXE:  nxt = S_HOLD;
      S_HOLD: if (done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      tick  <= '0;
    end else begin
      state <= nxt;
      if (state == S_IDLE || done) tick <= '0;
      else if (!stall)             tick <= tick + 1'b1;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_valid) |=> $stable(tick));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/bytelogic_exec.sv
module bytelogic_exec
  import bl_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 8,
  parameter int BANK_W        = 2,
  parameter int TICKS_PER_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              fetch_req,
  input  logic              fetch_valid,
  input  logic [DATA_W-1:0] fetch_byte,
  input  logic [DATA_W-1:0] acc_in,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ind,
  output logic              ram_re,
  output logic              ram_rd_latch,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              ram_we,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              done,
  output logic [1:0]        instr_len,
  output logic [1:0]        instr_cyc,
  output logic              illegal
);
  localparam int REG_IDX_W = 3;
  localparam int MAX_CYC   = 2;
  localparam int TICK_W    = $clog2(TICKS_PER_CYC * MAX_CYC);

  state_e              state;
  logic [TICK_W-1:0]   tick;
  logic [7:0]          opc_q, opc_cur;
  logic [ADDR_W-1:0]   adr_q, ptr_q, reg_addr;
  logic [DATA_W-1:0]   imm_q, opd_q, left_v, right_v, result;
  logic [REG_IDX_W-1:0] reg_idx;
  dec_t                dec;
  logic                dest_mem, needs_addr, needs_imm;
  logic                in_exe, in_opr;

  assign opc_cur = (state == S_OPC) ? fetch_byte[7:0] : opc_q;

  bl_decode u_dec (
    .opcode(opc_cur), .dec(dec), .dest_mem(dest_mem),
    .needs_addr(needs_addr), .needs_imm(needs_imm)
  );

  bl_seq #(.TICKS_PER_CYC(TICKS_PER_CYC), .MAX_CYC(MAX_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_valid(fetch_valid),
    .dec(dec), .needs_addr(needs_addr), .needs_imm(needs_imm),
    .state(state), .tick(tick), .fetch_req(fetch_req), .done(done)
  );

  // operand capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opc_q <= '0;
      adr_q <= '0;
      imm_q <= '0;
      ptr_q <= '0;
      opd_q <= '0;
    end else begin
      case (state)
        S_OPC: if (fetch_valid) opc_q <= fetch_byte[7:0];
        S_ADR: if (fetch_valid) adr_q <= ADDR_W'(fetch_byte);
        S_IMM: if (fetch_valid) imm_q <= fetch_byte;
        S_PTR: ptr_q <= ADDR_W'(ram_rdata);
        S_OPR: opd_q <= ram_rdata;
        default: ;
      endcase
    end
  end

  // register file lives in RAM: bank * 8 + index
  assign reg_idx  = (dec.form == FM_ACC_IND) ? REG_IDX_W'(opc_q[0]) : opc_q[2:0];
  assign reg_addr = ADDR_W'({bank_sel, reg_idx});
  assign in_opr   = (state == S_OPR);
  assign in_exe   = (state == S_EXE);

  always_comb begin
    ram_addr = '0;
    case (state)
      S_PTR: ram_addr = reg_addr;
      S_OPR: begin
        if (dec.form == FM_ACC_IND)      ram_addr = ptr_q;
        else if (dec.form == FM_ACC_REG) ram_addr = reg_addr;
        else                             ram_addr = adr_q;
      end
      S_EXE: ram_addr = adr_q;
      default: ;
    endcase
  end

  assign ram_re       = (state == S_PTR) || in_opr;
  assign ram_ind      = in_opr && (dec.form == FM_ACC_IND);
  assign ram_rd_latch = in_opr && dest_mem;

  always_comb begin
    left_v = dest_mem ? opd_q : acc_in;
    case (dec.form)
      FM_DIR_ACC:             right_v = acc_in;
      FM_DIR_IMM, FM_ACC_IMM: right_v = imm_q;
      default:                right_v = opd_q;
    endcase
  end

  bl_alu #(.DATA_W(DATA_W)) u_alu (.op(dec.op), .a(left_v), .b(right_v), .y(result));

  assign ram_we    = in_exe && dest_mem;
  assign acc_we    = in_exe && !dest_mem;
  assign ram_wdata = result;
  assign acc_wdata = result;
  assign instr_len = dec.len;
  assign instr_cyc = dec.cyc;
  assign illegal   = done && !dec.legal;

  // verification event: a write has happened in the current instruction
  logic wr_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)                wr_seen <= 1'b0;
    else if (done)             wr_seen <= 1'b0;
    else if (acc_we || ram_we) wr_seen <= 1'b1;
  end

  // R8
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_we || ram_we) |-> !wr_seen);

  // R8
  legal_wrote_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !illegal) |-> wr_seen);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> !wr_seen);

  // R5
  latch_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_rd_latch |-> (ram_re && !ram_ind));

  // R4
  ind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_ind |-> ram_re);

endmodule

// File: tb/bytelogic_exec_test.sv
module bytelogic_exec_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       start = 0;
  logic [1:0] bank_sel = 0;
  logic       fetch_req, fetch_valid;
  logic [7:0] fetch_byte, acc_in, acc_wdata, ram_addr, ram_rdata, ram_wdata;
  logic       acc_we, ram_ind, ram_re, ram_rd_latch, ram_we, done, illegal;
  logic [1:0] instr_len, instr_cyc;

  always #2 clk = ~clk;  // 250 MHz

  bytelogic_exec uut (
    .clk(clk), .rst_n(rst_n), .start(start), .bank_sel(bank_sel),
    .fetch_req(fetch_req), .fetch_valid(fetch_valid), .fetch_byte(fetch_byte),
    .acc_in(acc_in), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .ram_addr(ram_addr), .ram_ind(ram_ind), .ram_re(ram_re),
    .ram_rd_latch(ram_rd_latch), .ram_rdata(ram_rdata), .ram_we(ram_we),
    .ram_wdata(ram_wdata), .done(done), .instr_len(instr_len),
    .instr_cyc(instr_cyc), .illegal(illegal)
  );

  localparam logic [7:0] PORT = 8'h90;
  int errors = 0, checks = 0;

  // memory model: dmem is the direct space (dmem[PORT] is the port latch)
  logic [7:0] dmem [256];
  logic [7:0] ihi [128];
  logic [7:0] pin_val = 8'h0F;
  logic [7:0] acc_m = 8'h00;
  assign acc_in = acc_m;

  always_comb begin
    if (ram_ind)
      ram_rdata = ram_addr[7] ? ihi[ram_addr[6:0]] : dmem[ram_addr];
    else if (ram_addr == PORT && !ram_rd_latch)
      ram_rdata = pin_val;
    else
      ram_rdata = dmem[ram_addr];
  end

  // fetch model
  logic [7:0] prog [3];
  int pc = 0, stall_left = 0, stall_plan = 0;
  assign fetch_valid = (stall_left == 0);
  assign fetch_byte  = (pc < 3) ? prog[pc] : 8'h00;
  always @(posedge clk) begin
    if (start) begin
      pc <= 0;
      stall_left <= stall_plan;
    end else if (fetch_req) begin
      if (stall_left > 0) stall_left <= stall_left - 1;
      else                pc <= pc + 1;
    end
  end

  typedef struct {
    bit         acc_w;
    logic [7:0] acc_v;
    bit         ram_w;
    logic [7:0] ram_a;
    logic [7:0] ram_v;
    int         len;
    int         cyc;
    bit         ill;
    int         clocks;
    string      req;
  } exp_t;
  exp_t sbq[$];

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fn(logic [3:0] grp, logic [7:0] x, logic [7:0] y);
    if (grp == 4'h5) return x & y;
    if (grp == 4'h6) return x ^ y;
    return x | y;
  endfunction

  function automatic logic [7:0] rd_dir(logic [7:0] a);  // pin view for ports
    return (a == PORT) ? pin_val : dmem[a];
  endfunction

  function automatic logic [7:0] rd_ind(logic [7:0] p);
    return p[7] ? ihi[p[6:0]] : dmem[p];
  endfunction

  // driver: predicts, queues, runs
  task automatic run(logic [7:0] b0, logic [7:0] b1, logic [7:0] b2, int stalls, string req);
    exp_t e;
    logic [3:0] hi = b0[7:4];
    logic [3:0] lo = b0[3:0];
    int base = int'(bank_sel) * 8;
    e.acc_w = 0; e.acc_v = 0; e.ram_w = 0; e.ram_a = 0; e.ram_v = 0;
    e.len = 1; e.cyc = 1; e.ill = 0; e.req = req;
    if (b0 == 8'hF4) begin
      e.acc_w = 1; e.acc_v = ~acc_m;
    end else if (hi >= 4 && hi <= 6 && lo >= 2) begin
      if (lo == 2) begin
        e.ram_w = 1; e.ram_a = b1; e.ram_v = fn(hi, dmem[b1], acc_m); e.len = 2;
      end else if (lo == 3) begin
        e.ram_w = 1; e.ram_a = b1; e.ram_v = fn(hi, dmem[b1], b2); e.len = 3; e.cyc = 2;
      end else if (lo == 4) begin
        e.acc_w = 1; e.acc_v = fn(hi, acc_m, b1); e.len = 2;
      end else if (lo == 5) begin
        e.acc_w = 1; e.acc_v = fn(hi, acc_m, rd_dir(b1)); e.len = 2;
      end else if (lo < 8) begin
        e.acc_w = 1; e.acc_v = fn(hi, acc_m, rd_ind(dmem[base + int'(lo) - 6]));
      end else begin
        e.acc_w = 1; e.acc_v = fn(hi, acc_m, dmem[base + int'(lo) - 8]);
      end
    end else begin
      e.ill = 1;
    end
    e.clocks = 12 * e.cyc + stalls;
    sbq.push_back(e);
    prog[0] = b0; prog[1] = b1; prog[2] = b2;
    stall_plan = stalls;
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    wait (sbq.size() == 0);
    repeat (2) @(posedge clk);
  endtask

  // monitor
  bit pending = 0, running = 0;
  int cnt = 0;
  bit seen_acc, seen_ram;
  logic [7:0] got_acc, got_ra, got_rv;
  always @(negedge clk) begin
    if (pending) begin
      pending = 0; running = 1; cnt = 0; seen_acc = 0; seen_ram = 0;
    end
    if (running) begin
      exp_t e;
      cnt++;
      if (acc_we) begin seen_acc = 1; got_acc = acc_wdata; acc_m = acc_wdata; end
      if (ram_we) begin seen_ram = 1; got_ra = ram_addr; got_rv = ram_wdata; dmem[ram_addr] = ram_wdata; end
      if (done) begin
        e = sbq.pop_front();
        running = 0;
        check(e.req, "acc write flag (R8)", int'(seen_acc), int'(e.acc_w));
        if (e.acc_w && seen_acc) check(e.req, "acc value", int'(got_acc), int'(e.acc_v));
        check(e.req, "ram write flag (R8)", int'(seen_ram), int'(e.ram_w));
        if (e.ram_w && seen_ram) begin
          check(e.req, "ram addr", int'(got_ra), int'(e.ram_a));
          check(e.req, "ram value", int'(got_rv), int'(e.ram_v));
        end
        check(e.req, "illegal (R9)", int'(illegal), int'(e.ill));
        check(e.req, "instr_len (R6)", int'(instr_len), e.len);
        check(e.req, "bytes fetched (R6)", pc, e.len);
        check(e.req, "instr_cyc (R7)", int'(instr_cyc), e.cyc);
        check(e.req, "done clock (R7)", cnt, e.clocks);
      end
    end
    if (start) pending = 1;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 128; i++) ihi[i] = 8'(i * 13 + 1);
    dmem[PORT] = 8'hF0;                 // port latch; pin reads 0x0F
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    check("R11", "fetch_req", int'(fetch_req), 0);
    check("R11", "done", int'(done), 0);
    check("R11", "writes", int'(acc_we | ram_we), 0);
    check("R11", "illegal", int'(illegal), 0);
    rst_n = 1;
    repeat (2) @(posedge clk);

    run(8'h44, 8'h5A, 8'h00, 0, "R1 ORL A,#");      // 00|5A=5A
    run(8'h54, 8'h0F, 8'h00, 0, "R1 ANL A,#");      // 0A
    run(8'h64, 8'hFF, 8'h00, 0, "R1 XRL A,#");      // F5
    run(8'hF4, 8'h00, 8'h00, 0, "R2 CPL A");        // 0A
    dmem[3] = 8'h30;
    run(8'h4B, 8'h00, 8'h00, 0, "R3 ORL A,R3 bank0");
    bank_sel = 2; dmem[21] = 8'h0F; dmem[5] = 8'hFF;
    run(8'h5D, 8'h00, 8'h00, 0, "R3 ANL A,R5 bank2");
    bank_sel = 1; dmem[9] = 8'hA0; ihi[8'h20] = 8'h55;
    run(8'h67, 8'h00, 8'h00, 0, "R4 XRL A,@R1 upper");
    dmem[8] = 8'h40; dmem[8'h40] = 8'h11;
    run(8'h46, 8'h00, 8'h00, 0, "R4 ORL A,@R0 lower");
    bank_sel = 0;
    run(8'h54, 8'h00, 8'h00, 0, "R1 clear acc");
    run(8'h45, PORT, 8'h00, 0, "R5 ORL A,port pin");      // 0F
    run(8'h54, 8'h03, 8'h00, 0, "R1 ANL A,#03");          // 03
    run(8'h42, PORT, 8'h00, 0, "R5 ORL port,A latch");    // F0|03=F3
    dmem[8'h30] = 8'hFF;
    run(8'h53, 8'h30, 8'h3C, 0, "R6 ANL dir,# 3byte");    // 3C
    run(8'h63, PORT, 8'hFF, 0, "R5 XRL port,# latch");    // F3^FF=0C
    dmem[8'h31] = 8'h81;
    run(8'h62, 8'h31, 8'h00, 0, "R8 XRL dir,A");
    run(8'h52, 8'h31, 8'h00, 0, "R8 ANL dir,A");
    run(8'h55, 8'h31, 8'h00, 0, "R1 ANL A,dir");
    run(8'h40, 8'h00, 8'h00, 0, "R9 illegal 40");
    run(8'hA5, 8'h00, 8'h00, 0, "R9 illegal A5");
    run(8'h44, 8'h80, 8'h00, 3, "R10 stall 3");
    run(8'h43, 8'h32, 8'h0C, 2, "R10 stall 3byte");
    run(8'hF4, 8'h00, 8'h00, 1, "R10 stall CPL");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule